// File: doc/BRIEF.md
# Fault Escalation and Debug Cause Recorder

This block sits next to the exception logic of a processor core. Each cycle it looks at the configurable fault requests (memory-protection, bus and usage class faults in the default build). For each one it decides whether the fault can be handled by its own handler or has to become a hard fault. A fault is promoted to a hard fault when its handler is disabled, or when its priority is not urgent enough to preempt the code that is running. A read error on the exception vector table always produces a hard fault.

The block keeps two sticky status registers. The hard-fault status register records promoted faults, vector-table errors and debug activity. The debug status register records five kinds of halt cause. Both registers are cleared by writing ones, and both are read through a single selectable read port. Handler dispatch, stacking and the external debug port are handled elsewhere. This block only makes the promotion decision and keeps the records.

Top module: `fault_escalation_top`

## Requirements
- R1: A configurable fault request i whose enable bit is 0 is escalated. One clock edge later `hard_req_o` is 1, bit i of `cfg_take_o` is 0, and bit 30 (forced) of the hard-fault status register is 1.
- R2: An enabled fault i preempts only when its priority field `flt_prio[i*PRIO_W +: PRIO_W]` is strictly less than `cur_prio` (a lower value is more urgent). If the field is equal to or greater than `cur_prio`, the fault is escalated exactly as in R1.
- R3: An enabled fault that preempts is passed through. Bit i of `cfg_take_o` is 1 one clock edge later. That fault leaves `hard_req_o` and the hard-fault status register unchanged.
- R4: When `vt_err` is 1, `hard_req_o` is 1 one clock edge later and bit 1 (vector table) of the hard-fault status register is set. This happens regardless of priorities and enables.
- R5: After reset, `hard_req_o`, `cfg_take_o` and both status registers are 0.
- R6: `rd_data` shows the hard-fault status register when `rd_sel` is 0 and the debug status register when `rd_sel` is 1, with no clock delay.
- R7: A write (`wr_en` = 1) clears every bit where `wr_data` is 1 in the register chosen by `wr_sel` (0 = hard-fault, 1 = debug). Bits written with 0 keep their value. Without a write, status bits never fall.
- R8: Each bit of `dbg_evt` sets its own sticky bit at the same position of the debug status register: bit 0 halt or step request, bit 1 breakpoint, bit 2 watchpoint match, bit 3 vector catch, bit 4 external debug request.
- R9: Any nonzero `dbg_evt` also sets bit 31 (debug event) of the hard-fault status register.
- R10: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_req | input | NUM_FLT | Configurable fault requests |
| flt_en | input | NUM_FLT | Handler enable per fault |
| flt_prio | input | NUM_FLT*PRIO_W | Packed priority per fault, fault i at bits i*PRIO_W |
| cur_prio | input | PRIO_W | Current execution priority |
| vt_err | input | 1 | Vector-table read error |
| dbg_evt | input | 5 | Debug causes (halt, breakpoint, watchpoint, vector catch, external) |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 1 | Write target: 0 hard-fault, 1 debug |
| wr_data | input | 32 | Clear mask |
| rd_sel | input | 1 | Read source: 0 hard-fault, 1 debug |
| rd_data | output | 32 | Selected status register |
| hard_req_o | output | 1 | Hard fault request (registered) |
| cfg_take_o | output | NUM_FLT | Configurable faults passed to their handlers (registered) |

## Verification
The hardest case to reach is a set event and a clearing write that land on the same status bit in the same cycle. This matters for both the forced bit and a debug cause bit. The driver makes it happen by putting the escalating fault, or the debug event, in the same step as the write mask that covers that bit. The stimulus also covers the priority boundary where the fault priority equals the current priority. It mixes a preempting fault and a non-preempting fault in one cycle, so that `cfg_take_o` and `hard_req_o` are both active together.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  localparam int DATA_W    = 32;
  localparam int DBG_W     = 5;
  localparam int HF_VT_BIT = 1;
  localparam int HF_FORCED = 30;
  localparam int HF_DBGEVT = 31;

  // lower value = more urgent; preemption needs a strictly lower value
  function automatic logic can_preempt(input logic [7:0] fprio, input logic [7:0] cprio);
    return fprio < cprio;
  endfunction

  function automatic logic must_escalate(input logic en, input logic [7:0] fprio,
                                         input logic [7:0] cprio);
    return !en || !can_preempt(fprio, cprio);
  endfunction
endpackage

// File: rtl/fault_gate.sv
module fault_gate
  import fault_esc_pkg::*;
#(
  parameter int NUM_FLT = 3,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_FLT-1:0]        req,
  input  logic [NUM_FLT-1:0]        en,
  input  logic [NUM_FLT*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         cur,
  output logic [NUM_FLT-1:0]        esc,
  output logic [NUM_FLT-1:0]        take
);
  for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
    logic [7:0] fp, cp;
    always_comb begin
      fp = 8'(prio[i*PRIO_W +: PRIO_W]);
      cp = 8'(cur);
      esc[i]  = req[i] && must_escalate(en[i], fp, cp);
      take[i] = req[i] && !must_escalate(en[i], fp, cp);
    end
  end
endmodule

// File: rtl/sticky_w1c.sv
module sticky_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/fault_escalation_top.sv
module fault_escalation_top
  import fault_esc_pkg::*;
#(
  parameter int NUM_FLT = 3,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_FLT-1:0]        flt_req,
  input  logic [NUM_FLT-1:0]        flt_en,
  input  logic [NUM_FLT*PRIO_W-1:0] flt_prio,
  input  logic [PRIO_W-1:0]         cur_prio,
  input  logic                      vt_err,
  input  logic [4:0]                dbg_evt,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [31:0]               wr_data,
  input  logic                      rd_sel,
  output logic [31:0]               rd_data,
  output logic                      hard_req_o,
  output logic [NUM_FLT-1:0]        cfg_take_o
);
  logic [NUM_FLT-1:0] esc_w, take_w;
  logic               any_esc, any_dbg, hard_w;
  logic [DATA_W-1:0]  hf_set, hf_clr, hf_q;
  logic [DATA_W-1:0]  dbg_set, dbg_clr, dbg_q;

  fault_gate #(.NUM_FLT(NUM_FLT), .PRIO_W(PRIO_W)) u_gate (
    .req(flt_req), .en(flt_en), .prio(flt_prio), .cur(cur_prio),
    .esc(esc_w), .take(take_w)
  );

  always_comb begin
    any_esc = |esc_w;
    any_dbg = |dbg_evt;
    hard_w  = any_esc || vt_err;
    hf_set  = '0;
    hf_set[HF_VT_BIT] = vt_err;
    hf_set[HF_FORCED] = any_esc;
    hf_set[HF_DBGEVT] = any_dbg;
    dbg_set = DATA_W'(dbg_evt);
    hf_clr  = (wr_en && !wr_sel) ? wr_data : '0;
    dbg_clr = (wr_en &&  wr_sel) ? wr_data : '0;
  end

  sticky_w1c #(.W(DATA_W)) u_hf (
    .clk(clk), .rst_n(rst_n), .set(hf_set), .clr(hf_clr), .q(hf_q)
  );

  sticky_w1c #(.W(DATA_W)) u_dbg (
    .clk(clk), .rst_n(rst_n), .set(dbg_set), .clr(dbg_clr), .q(dbg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_req_o <= 1'b0;
      cfg_take_o <= '0;
    end else begin
      hard_req_o <= hard_w;
      cfg_take_o <= take_w;
    end
  end

  assign rd_data = rd_sel ? dbg_q : hf_q;
endmodule

// File: rtl/fault_escalation_chk.sv
module fault_escalation_chk #(
  parameter int NUM_FLT = 3,
  parameter int PRIO_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_FLT-1:0]        flt_req,
  input logic [NUM_FLT-1:0]        flt_en,
  input logic                      vt_err,
  input logic [4:0]                dbg_evt,
  input logic                      wr_en,
  input logic                      wr_sel,
  input logic                      hard_req_o,
  input logic [NUM_FLT-1:0]        cfg_take_o,
  input logic [31:0]               hf_q,
  input logic [31:0]               dbg_q
);
  p_disabled_escalates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flt_req & ~flt_en)) |=> (hard_req_o && hf_q[30]));

  p_no_take_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (~flt_en != '0) |=> ((cfg_take_o & ~$past(flt_en)) == '0));

  p_vector_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vt_err |=> (hard_req_o && hf_q[1]));

  p_debug_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_evt != '0) |=> ((dbg_q[4:0] & $past(dbg_evt)) == $past(dbg_evt)));

  p_debug_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_evt != '0) |=> hf_q[31]);

  p_sticky_hf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> (($past(hf_q) & ~hf_q) == '0));

  p_sticky_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> (($past(dbg_q) & ~dbg_q) == '0));
endmodule

bind fault_escalation_top fault_escalation_chk #(.NUM_FLT(NUM_FLT), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_en(flt_en), .vt_err(vt_err),
  .dbg_evt(dbg_evt), .wr_en(wr_en), .wr_sel(wr_sel), .hard_req_o(hard_req_o),
  .cfg_take_o(cfg_take_o), .hf_q(hf_q), .dbg_q(dbg_q)
);

// File: tb/test_fault_escalation_top.sv
module test_fault_escalation_top;
  localparam int PERIOD = 10;
  localparam int NF = 3;
  localparam int PW = 3;

  typedef struct {
    logic          hard;
    logic [NF-1:0] take;
    logic [31:0]   rd;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] flt_req = '0, flt_en = '0;
  logic [NF*PW-1:0] flt_prio = '0;
  logic [PW-1:0] cur_prio = '0;
  logic vt_err = 0;
  logic [4:0] dbg_evt = '0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic hard_req_o;
  logic [NF-1:0] cfg_take_o;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [31:0] hf_m = '0, dbg_m = '0;

  always #(PERIOD/2) clk = ~clk;

  fault_escalation_top #(.NUM_FLT(NF), .PRIO_W(PW)) i_fault_escalation_top (
    .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_en(flt_en), .flt_prio(flt_prio),
    .cur_prio(cur_prio), .vt_err(vt_err), .dbg_evt(dbg_evt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .hard_req_o(hard_req_o), .cfg_take_o(cfg_take_o)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apply(input logic [NF-1:0] req, input logic [NF-1:0] en,
                       input logic [NF*PW-1:0] pr, input logic [PW-1:0] cur,
                       input logic vt, input logic [4:0] dbg, input logic wr,
                       input logic wsel, input logic [31:0] wd, input logic rsel,
                       input string tag);
    exp_t e;
    logic [NF-1:0] esc, tk;
    logic [31:0] hs, ds;
    @(negedge clk);
    flt_req = req; flt_en = en; flt_prio = pr; cur_prio = cur; vt_err = vt;
    dbg_evt = dbg; wr_en = wr; wr_sel = wsel; wr_data = wd; rd_sel = rsel;
    for (int i = 0; i < NF; i++) begin
      logic [PW-1:0] p;
      p = pr[i*PW +: PW];
      esc[i] = req[i] & (~en[i] | ~(p < cur));
      tk[i]  = req[i] & ~esc[i];
    end
    hs = '0; hs[1] = vt; hs[30] = |esc; hs[31] = |dbg;
    ds = {27'b0, dbg};
    hf_m  = (hf_m  & ~((wr && !wsel) ? wd : 32'h0)) | hs;
    dbg_m = (dbg_m & ~((wr &&  wsel) ? wd : 32'h0)) | ds;
    e.hard = (|esc) | vt;
    e.take = tk;
    e.rd   = rsel ? dbg_m : hf_m;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic rsel, input string tag);
    apply('0, '0, '0, '0, 0, '0, 0, 0, '0, rsel, tag);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks += 3;
        if (hard_req_o !== e.hard) begin
          errors++;
          $display("FAIL %s hard_req actual=%0b expected=%0b", e.tag, hard_req_o, e.hard);
        end
        if (cfg_take_o !== e.take) begin
          errors++;
          $display("FAIL %s take actual=%b expected=%b", e.tag, cfg_take_o, e.take);
        end
        if (rd_data !== e.rd) begin
          errors++;
          $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R5: outputs and registers zero while in reset
    #(PERIOD/4);
    checks++;
    if (hard_req_o !== 0 || cfg_take_o !== '0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R5 reset actual=%0b/%b/%h expected=0/0/0", hard_req_o, cfg_take_o, rd_data);
    end
    @(negedge clk); rst_n = 1;
    idle(0, "R5 hf after reset");
    idle(1, "R5 dbg after reset / R6");
    // prio fields: fault0 bits[2:0], fault1 [5:3], fault2 [8:6]
    apply(3'b001, 3'b111, {3'd0, 3'd0, 3'd2}, 3'd5, 0, '0, 0, 0, '0, 0, "R3 preempt passes");
    apply(3'b010, 3'b111, {3'd0, 3'd5, 3'd0}, 3'd5, 0, '0, 0, 0, '0, 0, "R2 equal prio escalates");
    apply('0, '0, '0, 3'd0, 0, '0, 1, 0, 32'h4000_0000, 0, "R7 clear forced");
    apply(3'b100, 3'b011, {3'd0, 3'd0, 3'd0}, 3'd7, 0, '0, 0, 0, '0, 0, "R1 disabled escalates");
    apply(3'b001, 3'b110, '0, 3'd7, 0, '0, 1, 0, 32'h4000_0000, 0, "R10 set beats clear hf");
    apply('0, '0, '0, 3'd0, 0, '0, 1, 0, 32'hFFFF_FFFF, 0, "R7 clear all hf");
    apply('0, '0, '0, 3'd0, 1, '0, 0, 0, '0, 0, "R4 vector error");
    apply('0, '0, '0, 3'd0, 0, '0, 1, 0, 32'h0, 0, "R7 zero write keeps");
    apply('0, '0, '0, 3'd0, 0, 5'b00101, 0, 0, '0, 1, "R8 halt+watch");
    idle(0, "R9 debug flag in hf");
    apply('0, '0, '0, 3'd0, 0, 5'b11010, 1, 1, 32'h1, 1, "R8 R7 other causes, clear halt");
    apply('0, '0, '0, 3'd0, 0, 5'b00010, 1, 1, 32'h2, 1, "R10 set beats clear dbg");
    apply('0, '0, '0, 3'd0, 0, '0, 1, 0, 32'h2, 1, "R7 hf write leaves dbg");
    apply(3'b011, 3'b111, {3'd0, 3'd6, 3'd3}, 3'd4, 0, '0, 0, 0, '0, 0, "R2 R3 mixed");
    apply(3'b001, 3'b111, '0, 3'd0, 0, '0, 0, 0, '0, 0, "R2 prio0 vs cur0");
    apply(3'b111, 3'b111, {3'd1, 3'd2, 3'd3}, 3'd7, 0, '0, 0, 0, '0, 0, "R3 all preempt");
    idle(1, "R6 final dbg read");
    idle(0, "R6 final hf read");
    while (q.size() > 0) @(posedge clk);
    #(PERIOD);
    finish_run();
  end
endmodule